// File: doc/BRIEF.md
# Center-Referenced PWM Channel

This block drives the high-side output of a single pulse-width-modulated channel. An internal signed counter sweeps a window centered on zero: it starts at minus half the period, climbs by one per clock and folds back at the top of the window. Pulse edges are programmed as signed two's-complement positions on that count. The period, both edge registers, the mode bit and the dead time come straight from input ports. Their values take effect on the next clock.

A single mode bit chooses between two ways of placing the pulse. In symmetrical mode one edge register gives a pulse that is mirrored about count zero. In asymmetrical mode the two edge registers place the leading edge and the trailing edge independently. A dead-time value pulls both edges inward.

When the programmed pulse covers the whole window, or has no width at all, the channel raises a status flag and holds its output at a fixed level. A disable input parks the counter and silences the channel.

Top module: `pwmc_channel`

## Requirements
- R1: After reset, `pwm_hi_o`, `ovr_o` and `und_o` are all 0.
- R2: While enabled, the count advances by one per clock from MIN = -floor(P/2) up to MAX = P-1-floor(P/2), then returns to MIN, where P is `period_i` read as unsigned. The outputs seen after a clock edge reflect the count held just before that edge. The first edge after enable rises evaluates MIN.
- R3: When `mode_sym_i`=1, the output is high for counts c with -D+T <= c <= D-T. Here D is `duty_a_i` read as 16-bit two's complement and T is `dead_i` read as unsigned. `duty_b_i` has no effect in this mode.
- R4: When `mode_sym_i`=0, the output is high for counts c with A+T <= c <= B-T. Here A is `duty_a_i` and B is `duty_b_i`, both read as 16-bit two's complement.
- R5: A nonzero dead time T moves the leading edge T counts later and the trailing edge T counts earlier.
- R6: If the lower bound is <= MIN and the upper bound is >= MAX, `ovr_o`=1 and `pwm_hi_o` stays 1 for every count.
- R7: If the upper bound is below the lower bound, and R6 does not apply, `und_o`=1 and `pwm_hi_o` stays 0 for every count.
- R8: While `en_i`=0, `pwm_hi_o`, `ovr_o` and `und_o` are 0 one clock later and the counter is held at MIN.
- R9: `ovr_o` and `und_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable, active high |
| mode_sym_i | input | 1 | 1 = symmetrical, 0 = asymmetrical |
| period_i | input | 16 | Period in clocks, unsigned |
| duty_a_i | input | 16 | Leading-edge or symmetric edge position, two's complement |
| duty_b_i | input | 16 | Trailing-edge position (asymmetrical mode), two's complement |
| dead_i | input | 16 | Dead time in clocks, unsigned |
| pwm_hi_o | output | 1 | High-side pulse output |
| ovr_o | output | 1 | Over-modulation flag |
| und_o | output | 1 | Under-modulation flag |

## Verification
The assertions assume that every configuration input is a settled, known value whenever the channel is enabled. They also assume that the enable only returns to 0 between runs. They make no claim about a change of period in the middle of a window. The bench therefore writes a whole configuration while the channel is disabled, and only then raises the enable. It holds all inputs steady for more than one full window, and it uses only small periods so that every count in the window is observed.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  typedef enum logic {
    MODE_ASYM = 1'b0,
    MODE_SYM  = 1'b1
  } pwmc_mode_e;
endpackage

// File: rtl/pwmc_counter.sv
module pwmc_counter #(
  parameter int EXT_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [EXT_W-1:0] lim_min_i,
  input  logic signed [EXT_W-1:0] lim_max_i,
  output logic signed [EXT_W-1:0] cnt_o
);
  logic signed [EXT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= lim_min_i;
    else if (cnt_q >= lim_max_i) cnt_q <= lim_min_i;
    else                        cnt_q <= cnt_q + EXT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwmc_edges.sv
module pwmc_edges
  import pwmc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EXT_W = CNT_W + 2
) (
  input  logic                    mode_sym_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [CNT_W-1:0]        duty_a_i,
  input  logic [CNT_W-1:0]        duty_b_i,
  input  logic [CNT_W-1:0]        dead_i,
  output logic signed [EXT_W-1:0] lim_min_o,
  output logic signed [EXT_W-1:0] lim_max_o,
  output logic signed [EXT_W-1:0] lo_o,
  output logic signed [EXT_W-1:0] hi_o,
  output logic                    over_o,
  output logic                    under_o
);
  logic signed [EXT_W-1:0] half, per_x, da_x, db_x, dt_x;
  pwmc_mode_e mode;

  assign mode  = pwmc_mode_e'(mode_sym_i);
  assign half  = {3'b000, period_i[CNT_W-1:1]};
  assign per_x = {2'b00, period_i};
  assign da_x  = {{2{duty_a_i[CNT_W-1]}}, duty_a_i};
  assign db_x  = {{2{duty_b_i[CNT_W-1]}}, duty_b_i};
  assign dt_x  = {2'b00, dead_i};

  assign lim_min_o = -half;
  assign lim_max_o = per_x - half - EXT_W'(1);

  always_comb begin
    if (mode == MODE_SYM) begin
      lo_o = dt_x - da_x;
      hi_o = da_x - dt_x;
    end else begin
      lo_o = da_x + dt_x;
      hi_o = db_x - dt_x;
    end
  end

  // full-window coverage wins over an empty pulse
  assign over_o  = (lo_o <= lim_min_o) && (hi_o >= lim_max_o);
  assign under_o = !over_o && (hi_o < lo_o);
endmodule

// File: rtl/pwmc_output.sv
module pwmc_output #(
  parameter int EXT_W = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [EXT_W-1:0] cnt_i,
  input  logic signed [EXT_W-1:0] lo_i,
  input  logic signed [EXT_W-1:0] hi_i,
  input  logic                    over_i,
  input  logic                    under_i,
  output logic                    pwm_o,
  output logic                    ovr_o,
  output logic                    und_o
);
  logic in_win, pwm_d;

  assign in_win = (cnt_i >= lo_i) && (cnt_i <= hi_i);
  assign pwm_d  = en_i && (over_i || (!under_i && in_win));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_o <= 1'b0;
      ovr_o <= 1'b0;
      und_o <= 1'b0;
    end else begin
      pwm_o <= pwm_d;
      ovr_o <= en_i && over_i;
      und_o <= en_i && under_i;
    end
  end
endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             mode_sym_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_a_i,
  input  logic [CNT_W-1:0] duty_b_i,
  input  logic [CNT_W-1:0] dead_i,
  output logic             pwm_hi_o,
  output logic             ovr_o,
  output logic             und_o
);
  localparam int EXT_W = CNT_W + 2;

  logic signed [EXT_W-1:0] lim_min, lim_max, lo, hi, cnt;
  logic over, under;

  pwmc_edges #(.CNT_W(CNT_W), .EXT_W(EXT_W)) u_edges (
    .mode_sym_i(mode_sym_i), .period_i(period_i),
    .duty_a_i(duty_a_i), .duty_b_i(duty_b_i), .dead_i(dead_i),
    .lim_min_o(lim_min), .lim_max_o(lim_max),
    .lo_o(lo), .hi_o(hi), .over_o(over), .under_o(under)
  );

  pwmc_counter #(.EXT_W(EXT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .lim_min_i(lim_min), .lim_max_i(lim_max), .cnt_o(cnt)
  );

  pwmc_output #(.EXT_W(EXT_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cnt_i(cnt),
    .lo_i(lo), .hi_i(hi), .over_i(over), .under_i(under),
    .pwm_o(pwm_hi_o), .ovr_o(ovr_o), .und_o(und_o)
  );
endmodule

// File: rtl/pwmc_channel_chk.sv
module pwmc_channel_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pwm_hi_o,
  input logic ovr_o,
  input logic und_o
);
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_hi_o); // R8
  AST_OFF_NOFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ovr_o && !und_o)); // R8
  AST_OVR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> pwm_hi_o); // R6
  AST_UND_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_o |-> !pwm_hi_o); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovr_o, und_o})); // R9
endmodule

bind pwmc_channel pwmc_channel_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
  .pwm_hi_o(pwm_hi_o), .ovr_o(ovr_o), .und_o(und_o)
);

// File: tb/pwmc_channel_test.sv
module pwmc_channel_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic mode_sym_i = 1'b1;
  logic [15:0] period_i = '0, duty_a_i = '0, duty_b_i = '0, dead_i = '0;
  logic pwm_hi_o, ovr_o, und_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  pwmc_channel uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_sym_i(mode_sym_i),
    .period_i(period_i), .duty_a_i(duty_a_i), .duty_b_i(duty_b_i),
    .dead_i(dead_i), .pwm_hi_o(pwm_hi_o), .ovr_o(ovr_o), .und_o(und_o)
  );

  task automatic check(input bit act, input bit exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected window bounds and flags from the requirements
  int m_lo, m_hi, m_min, m_max;
  bit m_ovr, m_und;

  task automatic model(input int per, input bit sym, input int a, input int b, input int t);
    m_min = -(per / 2);
    m_max = per - 1 - per / 2;
    if (sym) begin m_lo = t - a; m_hi = a - t; end
    else     begin m_lo = a + t; m_hi = b - t; end
    m_ovr = (m_lo <= m_min) && (m_hi >= m_max);
    m_und = !m_ovr && (m_hi < m_lo);
  endtask

  // configure while disabled, enable, then check 1.5 windows of output
  task automatic run(input string req, input int per, input bit sym,
                     input int a, input int b, input int t);
    @(negedge clk_i);
    en_i = 1'b0;
    period_i = 16'(per); mode_sym_i = sym;
    duty_a_i = 16'(a); duty_b_i = 16'(b); dead_i = 16'(t);
    model(per, sym, a, b, t);
    @(negedge clk_i);
    en_i = 1'b1;
    for (int n = 0; n < per + per / 2; n++) begin
      int c;
      bit e;
      @(negedge clk_i);
      c = m_min + (n % per);
      e = m_ovr || (!m_und && c >= m_lo && c <= m_hi);
      check(pwm_hi_o, e, req, $sformatf("pwm at count %0d", c));
      check(ovr_o, m_ovr, req, "ovr_o");
      check(und_o, m_und, req, "und_o");
    end
  endtask

  task automatic t_reset;
    check(pwm_hi_o, 1'b0, "R1", "pwm after reset");
    check(ovr_o, 1'b0, "R1", "ovr after reset");
    check(und_o, 1'b0, "R1", "und after reset");
  endtask

  task automatic t_sym;
    run("R3", 20, 1'b1, 4, 0, 0);
    run("R3", 20, 1'b1, 4, 16'h7000, 0);   // duty_b ignored
    run("R3", 12, 1'b1, 0, -3, 0);
  endtask

  task automatic t_asym;
    run("R4", 20, 1'b0, -5, 3, 0);
    run("R4", 16, 1'b0, 2, 7, 0);
  endtask

  task automatic t_dead;
    run("R5", 20, 1'b1, 6, 0, 2);
    run("R5", 20, 1'b0, -5, 3, 1);
  endtask

  task automatic t_wrap;
    run("R2", 7, 1'b0, 2, 10, 0);   // odd period, window -3..3
    run("R2", 4, 1'b0, -2, -2, 0);
  endtask

  task automatic t_over;
    run("R6", 20, 1'b1, 10, 0, 0);
    run("R6", 10, 1'b0, -8, 9, 1);
  endtask

  task automatic t_under;
    run("R7", 20, 1'b1, -1, 0, 0);
    run("R7", 20, 1'b1, 2, 0, 3);
    run("R7", 20, 1'b0, 5, 2, 0);
  endtask

  task automatic t_enable;
    run("R8", 20, 1'b1, 10, 0, 0);  // over: output and flag high
    @(negedge clk_i);
    en_i = 1'b0;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk_i);
      check(pwm_hi_o, 1'b0, "R8", "pwm while disabled");
      check(ovr_o, 1'b0, "R8", "ovr while disabled");
    end
    duty_a_i = 16'd3;
    model(20, 1'b1, 3, 0, 0);
    en_i = 1'b1;
    for (int n = 0; n < 20; n++) begin
      int c;
      @(negedge clk_i);
      c = m_min + n;   // restart from MIN
      check(pwm_hi_o, (c >= m_lo && c <= m_hi), "R8", $sformatf("restart count %0d", c));
    end
    check(ovr_o && und_o, 1'b0, "R9", "both flags");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_sym();
    t_asym();
    t_dead();
    t_wrap();
    t_over();
    t_under();
    t_enable();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule